// File: doc/BRIEF.md
# Banked Single-Port RAM Arbiter

This block sits between up to three memory requesters (by convention an instruction fetch, an operand read and an operand write) and a window of on-chip RAM. The window is built from independent single-port banks of 2K 16-bit words. In every machine cycle, each bank can serve exactly one read or one write. Requests that target different banks are all served in the same cycle. When two or three requests land in the same bank, a fixed priority picks one winner. The losing requesters see their ready signal low and repeat the same request in the following cycle.

The window starts at a 2K-aligned base address inside a 64K-word address space and spans a parameterised number of banks. A request whose address falls outside the window is not this block's business. It receives no ready, touches no storage and does not compete for a bank. Read data comes from a register in each bank. It is steered back to the requester one cycle after that requester's ready.

Top module: `saram_arbiter`

## Requirements
- R1: An address is inside the window when BASE <= addr < BASE + NBANK*2048. The bank is bits [15:11] of (addr - BASE), narrowed to the bank-index width, and the word within the bank is bits [10:0]. Defaults are BASE = 0x8000 and NBANK = 2, so bank 0 is 0x8000–0x87FF and bank 1 is 0x8800–0x8FFF.
- R2: A request with its address outside the window never raises its ready, writes no bank and takes no part in arbitration.
- R3: Requests to distinct banks are all granted (ready high) in the same cycle.
- R4: When several in-window requests target one bank, only the highest-indexed port is granted. The priority is port 2 (operand write) over port 1 (operand read) over port 0 (fetch).
- R5: A request that loses arbitration has its ready low in that cycle. It is granted on a later cycle once no higher-priority request targets its bank.
- R6: For a granted read (we low), the addressed word appears on that port's rdata in the cycle after the one in which ready was high.
- R7: A granted write stores wdata at the addressed word, and later reads return it. If a write and a read collide on one bank, the write goes first and the retried read returns the new value.
- R8: While rst_n is low, no port's ready is high and no bank is accessed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | NP | Per-port request valid (bit 0 fetch, bit 1 operand read, bit 2 operand write) |
| we | input | NP | Per-port write enable (1 = write, 0 = read) |
| addr | input | NP x AW | Per-port word address |
| wdata | input | NP x DW | Per-port write data |
| rdata | output | NP x DW | Per-port read data, valid the cycle after a granted read |
| ready | output | NP | Per-port grant, combinational in the request cycle |

## Verification
The assertions assume that a requester holds req, we, addr and wdata stable while the edge is sampled. They also assume the window does not wrap past the top of the 64K space, so the in-window test and bank index that the checker derives from the port values match the design's decode. The stimulus changes inputs only on the falling clock edge. It keeps BASE and NBANK at values whose window ends at or below 0x10000. It places every read after a write to the same word, so no expected value depends on uninitialised storage.

// File: rtl/sab_pkg.sv
package sab_pkg;
    // Port roles; the index is also the arbitration priority (higher wins).
    localparam int NPORT     = 3;
    localparam int PORT_FTCH = 0;
    localparam int PORT_OPRD = 1;
    localparam int PORT_OPWR = 2;
endpackage

// File: rtl/sab_decode.sv
module sab_decode #(
    parameter int           AW    = 16,
    parameter int           OFF_W = 11,
    parameter int           NB    = 2,
    parameter int           BW    = 1,
    parameter logic [AW-1:0] BASE = 16'h8000
) (
    input  logic [AW-1:0]    addr,
    output logic             in_win,
    output logic [BW-1:0]    bank,
    output logic [OFF_W-1:0] offset
);
    localparam int            HI_W = AW - OFF_W;
    localparam logic [HI_W-1:0] NB_HI = HI_W'(NB);

    logic [AW-1:0] rel;

    always_comb begin
        rel    = addr - BASE;
        in_win = (addr >= BASE) && (rel[AW-1:OFF_W] < NB_HI);
        bank   = rel[OFF_W +: BW];
        offset = rel[OFF_W-1:0];
    end
endmodule

// File: rtl/sab_grant.sv
module sab_grant #(
    parameter int NP  = 3,
    parameter int IXW = 2
) (
    input  logic [NP-1:0]  hit,
    output logic [NP-1:0]  gnt,
    output logic [IXW-1:0] win,
    output logic           en
);
    always_comb begin
        win = '0;
        gnt = '0;
        en  = |hit;
        // ascending scan: the last hit seen is the highest index
        for (int i = 0; i < NP; i++) begin
            if (hit[i]) win = IXW'(i);
        end
        if (en) gnt[win] = 1'b1;
    end
endmodule

// File: rtl/sab_bank.sv
module sab_bank #(
    parameter int DW    = 16,
    parameter int OFF_W = 11
) (
    input  logic             clk,
    input  logic             en,
    input  logic             we,
    input  logic [OFF_W-1:0] addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    q
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    q         <= mem[addr];
        end
    end
endmodule

// File: rtl/saram_arbiter.sv
module saram_arbiter #(
    parameter int            NP    = sab_pkg::NPORT,
    parameter int            AW    = 16,
    parameter int            DW    = 16,
    parameter int            OFF_W = 11,
    parameter int            NB    = 2,
    parameter logic [AW-1:0] BASE  = 16'h8000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          req,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  addr,
    input  logic [NP-1:0][DW-1:0]  wdata,
    output logic [NP-1:0][DW-1:0]  rdata,
    output logic [NP-1:0]          ready
);
    localparam int BW  = (NB > 1) ? $clog2(NB) : 1;
    localparam int IXW = (NP > 1) ? $clog2(NP) : 1;

    typedef struct packed {
        logic [NP-1:0][BW-1:0] sel;   // bank each port last read from
    } state_t;

    state_t st_d, st_q;

    logic [NP-1:0]             in_win;
    logic [NP-1:0][BW-1:0]     bank_ix;
    logic [NP-1:0][OFF_W-1:0]  off;
    logic [NB-1:0][NP-1:0]     hit;
    logic [NB-1:0][NP-1:0]     gnt;
    logic [NB-1:0][IXW-1:0]    win;
    logic [NB-1:0]             b_en;
    logic [NB-1:0][DW-1:0]     b_q;

    // per-port address decode
    for (genvar p = 0; p < NP; p++) begin : g_dec
        sab_decode #(.AW(AW), .OFF_W(OFF_W), .NB(NB), .BW(BW), .BASE(BASE)) u_dec (
            .addr   (addr[p]),
            .in_win (in_win[p]),
            .bank   (bank_ix[p]),
            .offset (off[p])
        );
    end

    // per-bank arbitration and storage
    for (genvar b = 0; b < NB; b++) begin : g_bank
        for (genvar p = 0; p < NP; p++) begin : g_hit
            assign hit[b][p] = rst_n && req[p] && in_win[p] && (bank_ix[p] == BW'(b));
        end

        sab_grant #(.NP(NP), .IXW(IXW)) u_gnt (
            .hit (hit[b]),
            .gnt (gnt[b]),
            .win (win[b]),
            .en  (b_en[b])
        );

        sab_bank #(.DW(DW), .OFF_W(OFF_W)) u_mem (
            .clk   (clk),
            .en    (b_en[b]),
            .we    (we[win[b]]),
            .addr  (off[win[b]]),
            .wdata (wdata[win[b]]),
            .q     (b_q[b])
        );
    end

    // next-state and outputs
    always_comb begin
        st_d  = st_q;
        ready = '0;
        for (int p = 0; p < NP; p++) begin
            for (int b = 0; b < NB; b++) begin
                if (gnt[b][p]) ready[p] = 1'b1;
            end
            if (ready[p] && !we[p]) st_d.sel[p] = bank_ix[p];
            rdata[p] = b_q[st_q.sel[p]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

module saram_arbiter_chk #(
    parameter int            NP    = 3,
    parameter int            AW    = 16,
    parameter int            DW    = 16,
    parameter int            OFF_W = 11,
    parameter int            NB    = 2,
    parameter logic [AW-1:0] BASE  = 16'h8000
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NP-1:0]         req,
    input logic [NP-1:0]         we,
    input logic [NP-1:0][AW-1:0] addr,
    input logic [NP-1:0][DW-1:0] wdata,
    input logic [NP-1:0][DW-1:0] rdata,
    input logic [NP-1:0]         ready
);
    function automatic logic in_w(input logic [AW-1:0] a);
        int unsigned ia = a;
        int unsigned lo = BASE;
        return (ia >= lo) && (ia < lo + NB * (1 << OFF_W));
    endfunction

    function automatic int unsigned bk(input logic [AW-1:0] a);
        int unsigned ia = a;
        int unsigned lo = BASE;
        return (ia - lo) >> OFF_W;
    endfunction

    // R8: no grant while reset is held
    a_r8_quiet_reset: assert property (@(posedge clk) !rst_n |-> (ready == '0));

    for (genvar i = 0; i < NP; i++) begin : g_i
        // R2: ready only for a live request inside the window
        a_r2_only_in_window: assert property (@(posedge clk) disable iff (!rst_n)
            ready[i] |-> (req[i] && in_w(addr[i])));

        for (genvar j = i + 1; j < NP; j++) begin : g_j
            // R4: a higher port on the same bank blocks the lower one
            a_r4_priority: assert property (@(posedge clk) disable iff (!rst_n)
                (req[i] && req[j] && in_w(addr[i]) && in_w(addr[j])
                 && bk(addr[i]) == bk(addr[j])) |-> !ready[i]);
            // R3: two simultaneous grants never share a bank
            a_r3_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[i] && ready[j]) |-> (bk(addr[i]) != bk(addr[j])));
        end
    end

    // R5: the top in-window requester of each bank is always granted
    for (genvar i = 0; i < NP; i++) begin : g_top
        logic blocked;
        always_comb begin
            blocked = 1'b0;
            for (int j = i + 1; j < NP; j++) begin
                if (req[j] && in_w(addr[j]) && bk(addr[j]) == bk(addr[i])) blocked = 1'b1;
            end
        end
        a_r5_winner_served: assert property (@(posedge clk) disable iff (!rst_n)
            (req[i] && in_w(addr[i]) && !blocked) |-> ready[i]);
    end
endmodule

bind saram_arbiter saram_arbiter_chk #(
    .NP(NP), .AW(AW), .DW(DW), .OFF_W(OFF_W), .NB(NB), .BASE(BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready)
);

// File: tb/saram_arbiter_bench.sv
module saram_arbiter_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [2:0]         req = '0;
    logic [2:0]         we = '0;
    logic [2:0][15:0]   addr = '0;
    logic [2:0][15:0]   wdata = '0;
    logic [2:0][15:0]   rdata;
    logic [2:0]         ready;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    saram_arbiter u_saram_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ready(ready)
    );

    typedef struct packed {
        logic [2:0]  rq;
        logic [2:0]  wr;
        logic [15:0] a0, a1, a2, wd;
        logic [2:0]  rdy;
        logic [1:0]  chk;      // bit0: check rdata[0], bit1: check rdata[1]
        logic [15:0] e0, e1;
    } vec_t;

    // bit2 = operand write, bit1 = operand read, bit0 = fetch
    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{3'b100, 3'b100, 16'h0,    16'h0,    16'h8010, 16'h1111, 3'b100, 2'b00, 16'h0,    16'h0},    // R7 write
        '{3'b100, 3'b100, 16'h0,    16'h0,    16'h8810, 16'h2222, 3'b100, 2'b00, 16'h0,    16'h0},    // R1 bank 1
        '{3'b101, 3'b100, 16'h8010, 16'h0,    16'h8020, 16'h3333, 3'b100, 2'b00, 16'h0,    16'h0},    // R4 write beats fetch
        '{3'b011, 3'b000, 16'h8010, 16'h8810, 16'h0,    16'h0,    3'b011, 2'b11, 16'h1111, 16'h2222}, // R3 R5 retry, split banks
        '{3'b011, 3'b000, 16'h8020, 16'h8010, 16'h0,    16'h0,    3'b010, 2'b10, 16'h0,    16'h1111}, // R4 read beats fetch
        '{3'b001, 3'b000, 16'h8020, 16'h0,    16'h0,    16'h0,    3'b001, 2'b01, 16'h3333, 16'h0},    // R5 R6
        '{3'b110, 3'b100, 16'h0,    16'h8810, 16'h8810, 16'h4444, 3'b100, 2'b00, 16'h0,    16'h0},    // R7 write first
        '{3'b010, 3'b000, 16'h0,    16'h8810, 16'h0,    16'h0,    3'b010, 2'b10, 16'h0,    16'h4444}, // R7 new value
        '{3'b111, 3'b100, 16'h9000, 16'h8010, 16'h1010, 16'hDEAD, 3'b010, 2'b10, 16'h0,    16'h1111}, // R2 out of window
        '{3'b011, 3'b000, 16'h8010, 16'h8810, 16'h0,    16'h0,    3'b011, 2'b11, 16'h1111, 16'h4444}, // R2 no corruption
        '{3'b111, 3'b100, 16'h8820, 16'h8810, 16'h8820, 16'h5555, 3'b100, 2'b00, 16'h0,    16'h0},    // R4 three-way
        '{3'b011, 3'b000, 16'h8820, 16'h8810, 16'h0,    16'h0,    3'b010, 2'b10, 16'h0,    16'h4444},
        '{3'b001, 3'b000, 16'h8820, 16'h0,    16'h0,    16'h0,    3'b001, 2'b01, 16'h5555, 16'h0},
        '{3'b110, 3'b100, 16'h0,    16'h8000, 16'h8FFF, 16'h7777, 3'b110, 2'b00, 16'h0,    16'h0},    // R3 R1 top word
        '{3'b001, 3'b000, 16'h8FFF, 16'h0,    16'h0,    16'h0,    3'b001, 2'b01, 16'h7777, 16'h0},
        '{3'b100, 3'b100, 16'h0,    16'h0,    16'h7FFF, 16'hAAAA, 3'b000, 2'b00, 16'h0,    16'h0}     // R2 below base
    };

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        req      = v.rq;
        we       = v.wr;
        addr[0]  = v.a0;
        addr[1]  = v.a1;
        addr[2]  = v.a2;
        wdata[0] = 16'h0;
        wdata[1] = 16'h0;
        wdata[2] = v.wd;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R8: request held during reset is never granted
        @(negedge clk);
        apply('{3'b111, 3'b100, 16'h8010, 16'h8810, 16'h8020, 16'hBEEF, 3'b000, 2'b00, 16'h0, 16'h0});
        #1 check(ready == 3'b000, "R8 ready in reset", {13'h0, ready}, 16'h0);
        @(negedge clk);
        #1 check(ready == 3'b000, "R8 ready in reset", {13'h0, ready}, 16'h0);
        req = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check(ready == 3'b000, "R8 idle after reset", {13'h0, ready}, 16'h0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            apply(VECS[k]);
            #1 check(ready == VECS[k].rdy, $sformatf("R3 R4 R5 ready v%0d", k),
                     {13'h0, ready}, {13'h0, VECS[k].rdy});
            @(posedge clk);
            #1;
            if (VECS[k].chk[0])
                check(rdata[0] == VECS[k].e0, $sformatf("R6 R7 rdata0 v%0d", k), rdata[0], VECS[k].e0);
            if (VECS[k].chk[1])
                check(rdata[1] == VECS[k].e1, $sformatf("R6 R7 rdata1 v%0d", k), rdata[1], VECS[k].e1);
        end

        // R2: the 0x7FFF write was ignored; R1: 0x8000 and 0x87FF share bank 0 with 0x8010
        @(negedge clk);
        apply('{3'b010, 3'b000, 16'h0, 16'h8010, 16'h0, 16'h0, 3'b010, 2'b10, 16'h0, 16'h1111});
        #1 check(ready == 3'b010, "R2 ready", {13'h0, ready}, 16'h2);
        @(posedge clk);
        #1 check(rdata[1] == 16'h1111, "R2 rdata", rdata[1], 16'h1111);
        @(negedge clk);
        apply('{3'b111, 3'b000, 16'h8000, 16'h87FF, 16'h8010, 16'h0, 3'b100, 2'b00, 16'h0, 16'h0});
        #1 check(ready == 3'b100, "R1 same bank", {13'h0, ready}, 16'h4);
        @(negedge clk);
        req = '0;
        #1 check(ready == 3'b000, "R5 idle", {13'h0, ready}, 16'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule